// File: doc/BRIEF.md
# I2C Bit-Rate Prescaler

This block turns the system clock into the timing references that an I2C master's bus engine uses. The rate is set by one configuration register with two fields: an exponent `N` and a linear factor `M`. A first stage divides the clock by 2^N. A second stage divides the result by (M+1) to make a phase strobe. Ten phase strobes make one bus bit, so the bit rate is f_clk / (2^N * 10 * (M+1)). For example, a 48 MHz clock with N=2 and M=11 gives 12 MHz after the first stage and a 100 kHz bit rate.

The phase strobe carries a phase index from 0 to 9. The bus engine uses that index to place the SCL falling and rising edges and the SDA sample point inside each bit. A separate bit tick marks the last phase of every bit. Writing the register restarts both stages from zero, so the old setting never leaves a period that is too long or too short. While the controller enable is low, both stages are held at zero.

Top module: `i2c_rate_prescaler`

## Requirements
- R1: A write (`cfg_we` high at a clock edge) stores `cfg_wdata[2:0]` as N and `cfg_wdata[6:3]` as M. From the next cycle on, `cfg_rdata` returns the stored fields in the same bit positions.
- R2: `cfg_wdata` bits 7 and above are ignored. `cfg_rdata` bits 7 and above always read as zero.
- R3: With enable high and no write, `phase_stb` is high for exactly one cycle after every 2^N*(M+1)-th enabled clock edge counted from the last restart, and low at all other times.
- R4: Successive strobes carry `phase_idx` values 0,1,…,9 and then wrap to 0. `phase_idx` is 0 whenever `phase_stb` is low.
- R5: `bit_tick` is high exactly when `phase_stb` is high with `phase_idx` = 9, so bit ticks are 10*2^N*(M+1) cycles apart.
- R6: A write restarts both stages. No strobe is output in the cycle after the write edge, and the first new strobe follows the 2^N*(M+1)-th enabled edge after it, at phase index 0.
- R7: While `en` is low, no strobe or tick is output and both stages stay at zero. Counting starts from zero when `en` is raised.
- R8: Synchronous active-high `rst` clears all outputs and loads N=2, M=11 (`cfg_rdata` = 0x5A), which gives a bit period of 480 clock cycles.
- R9: The extreme settings work: N=0, M=0 gives a strobe on every enabled cycle, and N=7, M=15 gives a bit period of 20480 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Controller enable; low holds both stages at zero |
| cfg_we | input | 1 | Write strobe for the rate register |
| cfg_wdata | input | 8 | Write data: N in bits 2:0, M in bits 6:3 |
| cfg_rdata | output | 8 | Current rate register, upper bits zero |
| phase_stb | output | 1 | One-cycle strobe, ten per bus bit |
| phase_idx | output | 4 | Index 0..9 of the current strobe, 0 when idle |
| bit_tick | output | 1 | One-cycle pulse on the last phase of each bit |

## Verification
The assertions assume that `rst` is held for at least one clock edge before the first check. They also assume that `en` and `cfg_we` are plain synchronous levels that settle well before each edge. The bench meets both conditions by changing every input shortly after the falling clock edge and by starting with a multi-cycle reset. The bench writes `cfg_wdata` values with the ignored upper bit set and changes settings in the middle of a period. It also drops `en` partway through a count. The reference model sees each of these inputs exactly as the design does.

// File: rtl/presc_pkg.sv
package presc_pkg;
  localparam int PRESC_N_W    = 3;
  localparam int PRESC_M_W    = 4;
  localparam int PRESC_REG_W  = 8;
  localparam int PRESC_PHASES = 10;
  localparam int PRESC_RST_N  = 2;
  localparam int PRESC_RST_M  = 11;
endpackage

// File: rtl/presc_cfg_reg.sv
module presc_cfg_reg #(
  parameter int REG_W = presc_pkg::PRESC_REG_W,
  parameter int N_W   = presc_pkg::PRESC_N_W,
  parameter int M_W   = presc_pkg::PRESC_M_W,
  parameter int RST_N = presc_pkg::PRESC_RST_N,
  parameter int RST_M = presc_pkg::PRESC_RST_M
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [N_W-1:0]   n,
  output logic [M_W-1:0]   m,
  output logic [REG_W-1:0] rdata
);
  localparam int FIELD_W = N_W + M_W;

  logic unused_hi;
  assign unused_hi = ^wdata[REG_W-1:FIELD_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      n <= N_W'(RST_N);
      m <= M_W'(RST_M);
    end else if (we) begin
      n <= wdata[N_W-1:0];
      m <= wdata[FIELD_W-1:N_W];
    end
  end

  assign rdata = REG_W'({m, n});
endmodule

// File: rtl/presc_pow2_stage.sv
module presc_pow2_stage #(
  parameter int N_W = presc_pkg::PRESC_N_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           en,
  input  logic [N_W-1:0] n,
  output logic           wrap
);
  localparam int CNT_W = (1 << N_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] last;

  always_comb begin
    span = (CNT_W+1)'(1) << n;
    last = CNT_W'(span - (CNT_W+1)'(1));
  end

  assign wrap = en && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (en)
      cnt <= wrap ? '0 : cnt + CNT_W'(1);
  end
endmodule

// File: rtl/presc_phase_stage.sv
module presc_phase_stage #(
  parameter int M_W    = presc_pkg::PRESC_M_W,
  parameter int PHASES = presc_pkg::PRESC_PHASES,
  parameter int IDX_W  = $clog2(PHASES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  input  logic [M_W-1:0]   m,
  output logic             stb,
  output logic [IDX_W-1:0] idx,
  output logic             tick
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PHASES - 1);

  logic [M_W-1:0]   lcnt;
  logic [IDX_W-1:0] ph;
  logic             lwrap;

  assign lwrap = step && (lcnt == m);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      lcnt <= '0;
      ph   <= '0;
      stb  <= 1'b0;
      idx  <= '0;
      tick <= 1'b0;
    end else begin
      stb  <= lwrap;
      idx  <= lwrap ? ph : '0;
      tick <= lwrap && (ph == LAST_IDX);
      if (step)
        lcnt <= lwrap ? '0 : lcnt + M_W'(1);
      if (lwrap)
        ph <= (ph == LAST_IDX) ? '0 : ph + IDX_W'(1);
    end
  end
endmodule

// File: rtl/i2c_rate_prescaler.sv
module i2c_rate_prescaler #(
  parameter int REG_W  = presc_pkg::PRESC_REG_W,
  parameter int N_W    = presc_pkg::PRESC_N_W,
  parameter int M_W    = presc_pkg::PRESC_M_W,
  parameter int PHASES = presc_pkg::PRESC_PHASES,
  parameter int RST_N  = presc_pkg::PRESC_RST_N,
  parameter int RST_M  = presc_pkg::PRESC_RST_M,
  parameter int IDX_W  = $clog2(PHASES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  output logic             phase_stb,
  output logic [IDX_W-1:0] phase_idx,
  output logic             bit_tick
);
  logic [N_W-1:0] n_q;
  logic [M_W-1:0] m_q;
  logic           restart;
  logic           pre_wrap;

  // a write or a disabled controller parks both stages at zero
  assign restart = cfg_we || !en;

  presc_cfg_reg #(
    .REG_W(REG_W), .N_W(N_W), .M_W(M_W), .RST_N(RST_N), .RST_M(RST_M)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .n(n_q), .m(m_q), .rdata(cfg_rdata)
  );

  presc_pow2_stage #(.N_W(N_W)) u_pow2 (
    .clk(clk), .rst(rst), .clr(restart), .en(en), .n(n_q), .wrap(pre_wrap)
  );

  presc_phase_stage #(.M_W(M_W), .PHASES(PHASES), .IDX_W(IDX_W)) u_phase (
    .clk(clk), .rst(rst), .clr(restart), .step(pre_wrap), .m(m_q),
    .stb(phase_stb), .idx(phase_idx), .tick(bit_tick)
  );
endmodule

module presc_chk #(
  parameter int REG_W   = 8,
  parameter int FIELD_W = 7,
  parameter int PHASES  = 10,
  parameter int IDX_W   = 4,
  parameter int RST_VAL = 8'h5A
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             cfg_we,
  input logic [REG_W-1:0] cfg_wdata,
  input logic [REG_W-1:0] cfg_rdata,
  input logic             phase_stb,
  input logic [IDX_W-1:0] phase_idx,
  input logic             bit_tick
);
  // R1
  capture_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> cfg_rdata == REG_W'($past(cfg_wdata[FIELD_W-1:0])));
  // R4
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    phase_idx < IDX_W'(PHASES));
  // R4
  idx_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !phase_stb |-> phase_idx == '0);
  // R5
  tick_phase_chk: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> (phase_stb && phase_idx == IDX_W'(PHASES - 1)));
  // R6
  write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> !phase_stb);
  // R7
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!phase_stb && !bit_tick));
  // R8
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!phase_stb && !bit_tick && cfg_rdata == REG_W'(RST_VAL)));
endmodule

bind i2c_rate_prescaler presc_chk #(
  .REG_W(REG_W), .FIELD_W(N_W + M_W), .PHASES(PHASES), .IDX_W(IDX_W),
  .RST_VAL((RST_M << N_W) | RST_N)
) u_chk (
  .clk(clk), .rst(rst), .en(en), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .phase_stb(phase_stb), .phase_idx(phase_idx),
  .bit_tick(bit_tick)
);

// File: tb/i2c_rate_prescaler_tb.sv
module i2c_rate_prescaler_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       phase_stb;
  logic [3:0] phase_idx;
  logic       bit_tick;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit armed = 0;
  bit done = 0;

  // reference model state
  int   cnt = 0;
  int   mcfg = 8'h5A;
  logic e_stb = 0;
  int   e_idx = 0;
  logic e_tick = 0;

  always #10 clk = ~clk;

  i2c_rate_prescaler u_dut (
    .clk(clk), .rst(rst), .en(en), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .phase_stb(phase_stb), .phase_idx(phase_idx),
    .bit_tick(bit_tick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // behavioural model: enabled cycles since the last restart
  always @(posedge clk) begin
    if (rst) begin
      cnt = 0; mcfg = 8'h5A; e_stb = 0; e_idx = 0; e_tick = 0;
      armed = 1;
    end else if (cfg_we) begin
      mcfg = cfg_wdata & 8'h7F; cnt = 0; e_stb = 0; e_idx = 0; e_tick = 0;
    end else if (!en) begin
      cnt = 0; e_stb = 0; e_idx = 0; e_tick = 0;
    end else begin
      int per;
      cnt++;
      per = (1 << (mcfg & 7)) * ((mcfg >> 3) + 1);
      if (cnt % per == 0) begin
        e_stb = 1; e_idx = ((cnt / per) - 1) % 10; e_tick = (e_idx == 9);
      end else begin
        e_stb = 0; e_idx = 0; e_tick = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (armed && !done) begin
      check(phase_stb === e_stb, "R3 phase_stb", int'(phase_stb), int'(e_stb));
      check(phase_idx === 4'(e_idx), "R4 phase_idx", int'(phase_idx), e_idx);
      check(bit_tick === e_tick, "R5 bit_tick", int'(bit_tick), int'(e_tick));
      check(cfg_rdata === 8'(mcfg), "R1 cfg_rdata", int'(cfg_rdata), mcfg);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, 190000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); #1 cfg_we = 1; cfg_wdata = v;
    @(negedge clk); #1 cfg_we = 0;
  endtask

  task automatic bit_gap(output int gap);
    do @(negedge clk); while (bit_tick !== 1'b1);
    gap = 0;
    do begin @(negedge clk); gap++; end while (bit_tick !== 1'b1);
  endtask

  initial begin
    int gap;
    int k;
    idle(3);
    // R8 reset state
    check(phase_stb === 0 && bit_tick === 0, "R8 reset outputs", int'(phase_stb), 0);
    check(cfg_rdata === 8'h5A, "R8 reset register", int'(cfg_rdata), 8'h5A);
    #1 rst = 0;
    // R7 disabled: no strobes
    k = 0;
    repeat (40) begin @(negedge clk); if (phase_stb) k++; end
    check(k == 0, "R7 strobes while disabled", k, 0);
    #1 en = 1;
    // R8 default gives 480-cycle bits
    bit_gap(gap);
    check(gap == 480, "R8 default bit period", gap, 480);

    // R2 upper bit ignored, R9 fastest setting
    wr(8'h80);
    check(cfg_rdata === 8'h00, "R2 upper bits read zero", int'(cfg_rdata), 0);
    k = 0;
    repeat (25) begin @(negedge clk); if (phase_stb) k++; end
    check(k == 25, "R9 strobe every cycle at N=0 M=0", k, 25);

    // R6 restart: N=1 M=2 -> 6 cycles per phase; strobe seen at 7th negedge
    wr(8'h80 | (2 << 3) | 1);
    k = 1;
    while (phase_stb !== 1'b1 && k < 50) begin @(negedge clk); k++; end
    check(k == 7, "R6 first strobe after restart", k, 7);
    check(phase_idx === 4'd0, "R6 first index after restart", int'(phase_idx), 0);
    idle(23);
    wr(8'h1B);
    idle(77);
    wr(8'h1B);
    idle(150);

    // R7 enable drop mid-period
    @(negedge clk); #1 en = 0;
    idle(5);
    k = 0;
    if (phase_stb) k++;
    check(k == 0, "R7 quiet while disabled", k, 0);
    #1 en = 1;
    idle(300);

    // assorted settings, including writes while disabled
    for (int i = 0; i < 6; i++) begin
      logic [7:0] v;
      v = 8'((i * 37 + 5) & 8'hFF);
      v[6] = 1'b0;
      if (v[2:0] > 3) v[2:0] = 3'(i % 4);
      wr(v);
      idle(10 * (1 << v[2:0]) * (v[6:3] + 1) * 2 + 3);
      if (i == 3) begin
        @(negedge clk); #1 en = 0;
        wr(8'h09);
        idle(4);
        #1 en = 1;
        idle(250);
      end
    end

    // R9 slowest setting
    wr(8'h7F);
    bit_gap(gap);
    check(gap == 20480, "R9 slowest bit period", gap, 20480);

    // R8 reset mid-run restores default
    @(negedge clk); #1 rst = 1;
    idle(2);
    check(cfg_rdata === 8'h5A, "R8 reset mid-run register", int'(cfg_rdata), 8'h5A);
    #1 rst = 0;
    bit_gap(gap);
    check(gap == 480, "R8 bit period after reset", gap, 480);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule